// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Router

This block joins two eight-line priority interrupt units into a sixteen-line pair. One unit is the master and the other is the slave. Lines 0, 1 and 3 to 7 feed the master directly. Lines 8 to 15 feed the slave. Master input 2 is reserved for the cascade: the slave signals the master on that input by a single one-cycle pulse whenever it has an eligible request that it has not yet signalled. The master's pending-request flag is the CPU interrupt output.

On a one-cycle acknowledge strobe from the CPU, the router forms a vector from the current state.
- If the master's winner is a direct line, the vector is the master base plus that pin.
- If the master's winner is the cascade input, the vector is the slave base plus the slave's winning pin.
- If no winner exists, the vector is the spurious value, master base plus 7.

The router then decodes the vector to route the acceptance. A slave vector is accepted by the slave at its pin and also by the master at the cascade pin. Any other vector is accepted by the master alone. Both units are evaluated again on every cycle, so anything still pending is presented again after each acknowledge or end-of-interrupt.

Each unit behaves as follows:
- It latches rising edges into its request set and holds a per-line mask.
- It uses a fixed priority, in which a lower pin number is higher priority.
- It records an accepted pin as in service. Any in-service level at the same or higher priority blocks lower requests.
- A non-specific end-of-interrupt strobe clears that unit's highest-priority in-service bit.
- When special fully-nested mode is enabled, the master ignores its own in-service cascade bit when checking for blocking. The slave never applies this mode.

Top module: `pic_cascade_router`

## Requirements
- R1: After reset, cpu_intr and ack_valid are 0.
- R2: A rising edge on an unmasked master line n (n in 0,1,3..7) sets cpu_intr within 3 cycles. An acknowledge then returns vector 0x20+n.
- R3: A rising edge on an unmasked slave line n (8..15) makes the slave pulse master input 2 once, and cpu_intr rises within 4 cycles. An acknowledge returns vector 0x28+(n-8).
- R4: Once raised, cpu_intr stays at 1 until an acknowledge. It is 0 in the cycle after an acknowledge when nothing else is eligible.
- R5: An acknowledge with no eligible request returns the spurious vector 0x27, with ack_valid at 1.
- R6: An acknowledged slave vector also puts master pin 2 in service. Without special fully-nested mode, this blocks master lines 3..7 and further slave requests until eoi_master.
- R7: With sfn_en=1, the master's in-service bit 2 does not block a new slave request of higher slave priority. cpu_intr rises again and the acknowledge returns that slave vector.
- R8: sfn_en has no effect on the slave. A slave pin in service blocks lower-priority slave pins even with sfn_en=1, until eoi_slave.
- R9: irq_in[2] is ignored. A pulse on it alone leaves cpu_intr at 0.
- R10: A line whose mask_in bit is 1 does not raise cpu_intr but stays pending. Clearing the mask bit presents it.
- R11: When several lines are pending, the vector is chosen in this order, highest first: 0, 1, 8..15, 3..7. This is the order in which the acknowledges return them, with end-of-interrupt between them.
- R12: A non-specific end-of-interrupt clears the unit's highest-priority in-service bit, after which blocked pending requests are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; 7:0 master (bit 2 unused), 15:8 slave |
| mask_in | input | 16 | Per-line mask, 1 = inhibited |
| sfn_en | input | 1 | Special fully-nested mode, applied to the master only |
| eoi_master | input | 1 | Non-specific end-of-interrupt strobe to the master |
| eoi_slave | input | 1 | Non-specific end-of-interrupt strobe to the slave |
| cpu_ack | input | 1 | One-cycle acknowledge strobe from the CPU |
| cpu_intr | output | 1 | Interrupt request to the CPU |
| ack_valid | output | 1 | One cycle after cpu_ack: ack_vector is valid |
| ack_vector | output | 8 | Vector returned for the acknowledge |

## Verification
A sweep takes every non-cascade line on its own. It separates the master and slave vector bases and the path through the cascade pulse. A second sweep takes every unordered pair of lines. It fixes the full priority order, including the nesting of the slave between master pins 1 and 3.

Directed sequences cover the remaining behaviour:
- The same nested slave scenario is run with and without special fully-nested mode, which isolates the cascade-bit exclusion.
- The same scenario is run with an in-service slave pin 2 and the mode enabled, which shows the slave ignoring the mode.
- Masking, the idle cascade input line and an acknowledge with nothing pending each have their own sequence.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int PINS  = 8;
  localparam int PIN_W = $clog2(PINS);

  typedef struct packed {
    logic             valid;
    logic [PIN_W-1:0] pin;
  } pick_t;

  // Highest-priority (lowest index) eligible request; an in-service bit at
  // the same or higher level stops the search.
  function automatic pick_t pick_best(logic [PINS-1:0] req, logic [PINS-1:0] msk,
                                      logic [PINS-1:0] blk);
    pick_t r;
    logic  stop;
    r    = '0;
    stop = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      if (!stop) begin
        if (blk[i]) begin
          stop = 1'b1;
        end else if (req[i] && !msk[i]) begin
          r.valid = 1'b1;
          r.pin   = PIN_W'(i);
          stop    = 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic pick_t lowest_set(logic [PINS-1:0] v);
    return pick_best(v, '0, '0);
  endfunction

  // Vector formation at acknowledge time.
  function automatic logic [7:0] vector_for(pick_t m, pick_t s, logic [7:0] mbase,
                                            logic [7:0] sbase, int cpin);
    logic [7:0] v;
    if (!m.valid) v = mbase + 8'd7;
    else if (int'(m.pin) == cpin) v = s.valid ? (sbase + 8'(s.pin)) : (mbase + 8'd7);
    else v = mbase + 8'(m.pin);
    return v;
  endfunction
endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import pic_cascade_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_PIN  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] line_in,
  input  logic [PINS-1:0] mask_in,
  input  logic            sfn_en,
  input  logic            accept,
  input  logic [PIN_W-1:0] accept_pin,
  input  logic            eoi,
  output pick_t           best,
  output logic            raise,
  output logic            raised,
  output logic [PINS-1:0] edge_set
);
  logic [PINS-1:0] prev, irr, isr, blk, acc_vec, eoi_vec;
  logic            sfn_eff;
  pick_t           top_isr;

  assign sfn_eff  = sfn_en & IS_MASTER;
  assign edge_set = line_in & ~prev;

  always_comb begin
    blk = isr;
    if (sfn_eff) blk[CASC_PIN] = 1'b0;
  end

  assign best    = pick_best(irr, mask_in, blk);
  assign raise   = best.valid & ~raised;
  assign top_isr = lowest_set(isr);
  assign acc_vec = accept ? (PINS'(1) << accept_pin) : '0;
  assign eoi_vec = (eoi && top_isr.valid) ? (PINS'(1) << top_isr.pin) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      irr    <= '0;
      isr    <= '0;
      raised <= 1'b0;
    end else begin
      prev   <= line_in;
      irr    <= (irr & ~acc_vec) | edge_set;
      isr    <= (isr & ~eoi_vec) | acc_vec;
      raised <= accept ? 1'b0 : (raised | raise);
    end
  end

  // R4: a raised request is held until accepted
  a_r4_raised_holds: assert property (@(posedge clk) disable iff (!rst_n)
    raised && !accept |=> raised);
  // R12: an accepted pin is in service next cycle
  a_r12_accept_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !eoi |=> isr[$past(accept_pin)]);
endmodule

// File: rtl/pic_ack_resolve.sv
module pic_ack_resolve
  import pic_cascade_pkg::*;
#(
  parameter logic [7:0] MASTER_BASE = 8'h20,
  parameter logic [7:0] SLAVE_BASE  = 8'h28,
  parameter int         CASCADE_PIN = 2
) (
  input  logic             ack,
  input  pick_t            m_best,
  input  pick_t            s_best,
  output logic [7:0]       vector,
  output logic             acc_m,
  output logic [PIN_W-1:0] acc_m_pin,
  output logic             acc_s,
  output logic [PIN_W-1:0] acc_s_pin
);
  logic is_slave;

  assign vector    = vector_for(m_best, s_best, MASTER_BASE, SLAVE_BASE, CASCADE_PIN);
  assign is_slave  = (vector[7:PIN_W] == SLAVE_BASE[7:PIN_W]);
  assign acc_s     = ack & is_slave;
  assign acc_s_pin = vector[PIN_W-1:0];
  assign acc_m     = ack;
  assign acc_m_pin = is_slave ? PIN_W'(CASCADE_PIN) : vector[PIN_W-1:0];
endmodule

// File: rtl/pic_cascade_router.sv
module pic_cascade_router
  import pic_cascade_pkg::*;
#(
  parameter logic [7:0] MASTER_BASE = 8'h20,
  parameter logic [7:0] SLAVE_BASE  = 8'h28,
  parameter int         CASCADE_PIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   irq_in,
  input  logic [15:0]   mask_in,
  input  logic          sfn_en,
  input  logic          eoi_master,
  input  logic          eoi_slave,
  input  logic          cpu_ack,
  output logic          cpu_intr,
  output logic          ack_valid,
  output logic [7:0]    ack_vector
);
  localparam int UNITS = 2;

  logic [PINS-1:0]  line     [UNITS];
  logic [PINS-1:0]  edge_set [UNITS];
  pick_t            best     [UNITS];
  logic             raise    [UNITS];
  logic             raised   [UNITS];
  logic             acc      [UNITS];
  logic [PIN_W-1:0] acc_pin  [UNITS];
  logic [7:0]       vec_now;

  // Master pin CASCADE_PIN is fed by the slave's one-cycle raise pulse.
  always_comb begin
    line[0]              = irq_in[PINS-1:0];
    line[0][CASCADE_PIN] = raise[1];
    line[1]              = irq_in[2*PINS-1:PINS];
  end

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    pic_unit #(.IS_MASTER(g == 0), .CASC_PIN(CASCADE_PIN)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line[g]),
      .mask_in   (mask_in[g*PINS +: PINS]),
      .sfn_en    (sfn_en),
      .accept    (acc[g]),
      .accept_pin(acc_pin[g]),
      .eoi       ((g == 0) ? eoi_master : eoi_slave),
      .best      (best[g]),
      .raise     (raise[g]),
      .raised    (raised[g]),
      .edge_set  (edge_set[g])
    );
  end

  pic_ack_resolve #(.MASTER_BASE(MASTER_BASE), .SLAVE_BASE(SLAVE_BASE),
                    .CASCADE_PIN(CASCADE_PIN)) u_resolve (
    .ack      (cpu_ack),
    .m_best   (best[0]),
    .s_best   (best[1]),
    .vector   (vec_now),
    .acc_m    (acc[0]),
    .acc_m_pin(acc_pin[0]),
    .acc_s    (acc[1]),
    .acc_s_pin(acc_pin[1])
  );

  assign cpu_intr = raised[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      ack_valid  <= cpu_ack;
      if (cpu_ack) ack_vector <= vec_now;
    end
  end

  // R3: the cascade pulse lasts exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    raise[1] |=> !raise[1]);
  // R4: a slave that has signalled stays quiet
  a_r4_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    raised[1] |-> !raise[1]);
  // R4: the CPU request only rises after a master raise
  a_r4_intr_from_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_intr) |-> $past(raise[0]));
  // R5: nothing eligible yields the spurious vector
  a_r5_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !best[0].valid |=> ack_vector == MASTER_BASE + 8'd7);
  // R6: a slave acceptance also accepts master cascade pin
  a_r6_slave_implies_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    acc[1] |-> acc[0] && (int'(acc_pin[0]) == CASCADE_PIN));
  // R9: the external line on the cascade pin never records an edge alone
  a_r9_cascade_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in[CASCADE_PIN] && !raise[1] |-> !edge_set[0][CASCADE_PIN]);
  // R3: slave edges only come from slave lines
  a_r3_slave_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_set[1] & ~irq_in[2*PINS-1:PINS]) == '0);
endmodule

// File: tb/pic_cascade_router_bench.sv
module pic_cascade_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [15:0] mask_in = '0;
  logic        sfn_en = 1'b0;
  logic        eoi_master = 1'b0;
  logic        eoi_slave = 1'b0;
  logic        cpu_ack = 1'b0;
  logic        cpu_intr, ack_valid;
  logic [7:0]  ack_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pic_cascade_router u_pic_cascade_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_in(mask_in), .sfn_en(sfn_en),
    .eoi_master(eoi_master), .eoi_slave(eoi_slave), .cpu_ack(cpu_ack),
    .cpu_intr(cpu_intr), .ack_valid(ack_valid), .ack_vector(ack_vector)
  );

  function automatic int exp_vec(int n);
    return (n >= 8) ? (8'h28 + n - 8) : (8'h20 + n);
  endfunction

  // Position in the overall priority order (0 = highest).
  function automatic int rank(int n);
    if (n < 2) return n;
    if (n >= 8) return n - 6;
    return n + 7;
  endfunction

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [15:0] m);
    irq_in = irq_in | m;
    step(1);
    irq_in = irq_in & ~m;
  endtask

  task automatic ack(output int v);
    cpu_ack = 1'b1;
    step(1);
    cpu_ack = 1'b0;
    v = int'(ack_vector);
    chk("R5 ack_valid", int'(ack_valid), 1);
  endtask

  task automatic eoi(bit m, bit s);
    eoi_master = m;
    eoi_slave  = s;
    step(1);
    eoi_master = 1'b0;
    eoi_slave  = 1'b0;
  endtask

  task automatic retire(int n);
    eoi(1'b1, n >= 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    int a_first, a_second;
    step(3);
    chk("R1 cpu_intr", int'(cpu_intr), 0);
    chk("R1 ack_valid", int'(ack_valid), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 cpu_intr after release", int'(cpu_intr), 0);

    // R2 R3: every line alone
    for (int n = 0; n < 16; n++) begin
      if (n != 2) begin
        pulse(16'(1) << n);
        step(5);
        chk(n >= 8 ? "R3 intr" : "R2 intr", int'(cpu_intr), 1);
        if (n == 0) begin
          step(20);
          chk("R4 intr held", int'(cpu_intr), 1);
        end
        ack(v);
        chk(n >= 8 ? "R3 vector" : "R2 vector", v, exp_vec(n));
        chk("R4 intr after ack", int'(cpu_intr), 0);
        retire(n);
        step(3);
      end
    end

    // R11: every pair
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        if (a != 2 && b != 2) begin
          a_first  = (rank(a) < rank(b)) ? a : b;
          a_second = (a_first == a) ? b : a;
          pulse((16'(1) << a) | (16'(1) << b));
          step(6);
          ack(v);
          chk("R11 first", v, exp_vec(a_first));
          retire(a_first);
          step(6);
          chk("R12 second presented", int'(cpu_intr), 1);
          ack(v);
          chk("R11 second", v, exp_vec(a_second));
          retire(a_second);
          step(3);
        end
      end
    end

    // R10: masking
    mask_in = 16'h0020 | 16'h1000;
    pulse(16'h1020);
    step(6);
    chk("R10 masked", int'(cpu_intr), 0);
    mask_in = 16'h0020;
    step(6);
    chk("R10 slave unmasked", int'(cpu_intr), 1);
    ack(v);
    chk("R10 slave vector", v, exp_vec(12));
    retire(12);
    mask_in = '0;
    step(6);
    chk("R10 master unmasked", int'(cpu_intr), 1);
    ack(v);
    chk("R10 master vector", v, exp_vec(5));
    retire(5);
    step(3);

    // R9: cascade line itself
    pulse(16'h0004);
    step(6);
    chk("R9 intr", int'(cpu_intr), 0);

    // R5: spurious
    ack(v);
    chk("R5 spurious vector", v, 8'h27);
    eoi(1'b1, 1'b0);
    step(3);

    // R6: slave acceptance puts master pin 2 in service
    pulse(16'h0800);
    step(6);
    ack(v);
    chk("R6 slave vector", v, exp_vec(11));
    pulse(16'h0020);
    step(6);
    chk("R6 master 5 blocked", int'(cpu_intr), 0);
    eoi(1'b0, 1'b1);
    step(4);
    chk("R6 still blocked after slave eoi", int'(cpu_intr), 0);
    eoi(1'b1, 1'b0);
    step(4);
    chk("R6 released by master eoi", int'(cpu_intr), 1);
    ack(v);
    chk("R6 master vector", v, exp_vec(5));
    eoi(1'b1, 1'b0);
    step(3);

    // R7: nested slave request, without then with special fully-nested mode
    pulse(16'h2000);
    step(6);
    ack(v);
    chk("R7 outer vector nosfn", v, exp_vec(13));
    pulse(16'h0200);
    step(6);
    chk("R7 nested blocked nosfn", int'(cpu_intr), 0);
    eoi(1'b1, 1'b0);
    step(4);
    chk("R7 nested after eoi nosfn", int'(cpu_intr), 1);
    ack(v);
    chk("R7 nested vector nosfn", v, exp_vec(9));
    eoi(1'b0, 1'b1);
    eoi(1'b1, 1'b1);
    step(3);

    sfn_en = 1'b1;
    pulse(16'h2000);
    step(6);
    ack(v);
    chk("R7 outer vector sfn", v, exp_vec(13));
    pulse(16'h0200);
    step(6);
    chk("R7 nested passes sfn", int'(cpu_intr), 1);
    ack(v);
    chk("R7 nested vector sfn", v, exp_vec(9));
    eoi(1'b0, 1'b1);
    eoi(1'b1, 1'b1);
    step(3);

    // R8: slave ignores the mode
    pulse(16'h0400);
    step(6);
    ack(v);
    chk("R8 slave pin2 vector", v, exp_vec(10));
    eoi(1'b1, 1'b0);
    pulse(16'h1000);
    step(6);
    chk("R8 slave lower blocked", int'(cpu_intr), 0);
    eoi(1'b0, 1'b1);
    step(5);
    chk("R8 released by slave eoi", int'(cpu_intr), 1);
    ack(v);
    chk("R8 vector", v, exp_vec(12));
    eoi(1'b1, 1'b1);
    sfn_en = 1'b0;
    step(3);
    chk("R4 idle at end", int'(cpu_intr), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule